// File: doc/BRIEF.md
# Framer Alarm Interrupt Controller

This block collects the alarm conditions of a line framer and turns them into latched interrupt indications and one interrupt request line. Three alarms are levels: loss of basic frame alignment, loss of CRC multiframe alignment and loss of signalling multiframe alignment. Each level alarm is registered as a status bit. Three alarms are events: basic frame alignment word error, CRC multiframe alignment error and signalling multiframe alignment error. Each event is a single-cycle pulse and has no status bit.

A status bit that changes in either direction latches its indication bit. An event pulse latches its indication bit directly. A read of the indication register returns the latched bits and clears them. An enable register selects which indications drive the request line. Software writes the enable register and reads all three registers through one small port. Detecting the alarms is done elsewhere.

Top module: `framer_irq_ctrl`

## Requirements
- R1: After reset the status, indication and enable registers read as zero and `irq` is low.
- R2: Status bit 4 (frame lost) is high one clock after any of `frm_unlocked`, `frm_crit` or `crc_excess` is high, and low one clock after all of them are low.
- R3: Status bit 5 (CRC multiframe lost) follows `cmf_unlocked OR crc_excess` with one clock of delay.
- R4: Status bit 6 (signalling multiframe lost) follows the frame-lost condition OR `smf_crit` with one clock of delay.
- R5: A status bit that rises sets its indication bit, and a status bit that falls also sets it. The indication bit is set on the same clock edge at which the status bit changes.
- R6: A pulse on `evt_fas_err`, `evt_cmf_err` or `evt_smf_err` sets indication bit 0, 1 or 2 on the next clock edge.
- R7: While `rd_en` is high, `rd_data` shows the register at `rd_addr`: 0 is status, 1 is indication, 2 is enable and 3 reads zero. A read at address 1 clears the indication register on that clock edge. Reads at other addresses leave it unchanged.
- R8: An event or a status change in the same cycle as an indication read leaves its bit set after that clock edge.
- R9: `irq` is high exactly when some indication bit and its enable bit are both 1.
- R10: All three registers share one layout: the events sit at bits 0 to 2 and the levels at bits 4 to 6. Bits 3 and 7 always read zero, and a write to the enable register stores only bits 0 to 2 and 4 to 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_unlocked | input | 1 | Basic frame alignment not yet achieved |
| frm_crit | input | 1 | Frame-loss criteria met |
| crc_excess | input | 1 | Excessive CRC errors |
| cmf_unlocked | input | 1 | CRC multiframe alignment not achieved |
| smf_crit | input | 1 | Signalling multiframe loss criteria met |
| evt_fas_err | input | 1 | Pulse: basic frame alignment word error |
| evt_cmf_err | input | 1 | Pulse: CRC multiframe alignment error |
| evt_smf_err | input | 1 | Pulse: signalling multiframe alignment error |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, zero when `rd_en` is low |
| irq | output | 1 | Active-high interrupt request |

## Verification
A status register stuck at a wrong value appears at address 0 on the first read after the condition inputs change. The indication bits it fails to set appear at address 1 on the same read. A wrong indication state appears on `irq` one cycle after its cause, as long as the matching enable bit is set. It also appears at address 1 on the next read. A missing clear, or a clear that drops a new event, appears on the read that follows the clearing read. The bench therefore pairs every clearing read with a second read.

// File: rtl/fi_pkg.sv
package fi_pkg;
  localparam int REG_W   = 8;
  localparam int ADDR_W  = 2;
  localparam int NUM_SRC = 3;
  localparam int EVT_LSB = 0;
  localparam int LVL_LSB = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_STATUS = 2'd0,
    A_IND    = 2'd1,
    A_EN     = 2'd2,
    A_NONE   = 2'd3
  } addr_e;

  function automatic logic [REG_W-1:0] valid_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      m[EVT_LSB+i] = 1'b1;
      m[LVL_LSB+i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/fi_status.sv
module fi_status #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] cond,
  output logic [NSRC-1:0] stat_q,
  output logic [NSRC-1:0] toggle
);
  logic [NSRC-1:0] stat_d;
  logic            upd;

  always_comb begin
    stat_d = cond;
    toggle = cond ^ stat_q;
    upd    = |toggle;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   stat_q <= '0;
    else if (upd) stat_q <= stat_d;
  end
endmodule

// File: rtl/fi_latch.sv
module fi_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         clr,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic d;
    logic ce;
    always_comb begin
      ce = set[i] | clr;
      d  = set[i] | (q[i] & ~clr);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q[i] <= 1'b0;
      else if (ce) q[i] <= d;
    end
  end
endmodule

// File: rtl/fi_regs.sv
module fi_regs #(
  parameter int               REG_W  = 8,
  parameter int               ADDR_W = 2,
  parameter logic [REG_W-1:0] MASK   = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_we,
  input  logic [REG_W-1:0]  en_wdata,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [REG_W-1:0]  stat_reg,
  input  logic [REG_W-1:0]  ind_reg,
  output logic [REG_W-1:0]  en_reg,
  output logic [REG_W-1:0]  rd_data
);
  import fi_pkg::*;

  logic [REG_W-1:0] en_d;

  always_comb en_d = en_wdata & MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_reg <= '0;
    else if (en_we) en_reg <= en_d;
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (addr_e'(rd_addr))
        A_STATUS: rd_data = stat_reg;
        A_IND:    rd_data = ind_reg;
        A_EN:     rd_data = en_reg;
        default:  rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/framer_irq_ctrl.sv
module framer_irq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frm_unlocked,
  input  logic       frm_crit,
  input  logic       crc_excess,
  input  logic       cmf_unlocked,
  input  logic       smf_crit,
  input  logic       evt_fas_err,
  input  logic       evt_cmf_err,
  input  logic       evt_smf_err,
  input  logic       en_we,
  input  logic [7:0] en_wdata,
  input  logic       rd_en,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       irq
);
  import fi_pkg::*;

  localparam int               NSRC = NUM_SRC;
  localparam logic [REG_W-1:0] MASK = valid_mask();

  logic [NSRC-1:0]  cond;
  logic [NSRC-1:0]  evt;
  logic [NSRC-1:0]  stat_q;
  logic [NSRC-1:0]  toggle;
  logic [REG_W-1:0] stat_reg;
  logic [REG_W-1:0] set_w;
  logic [REG_W-1:0] ind_reg;
  logic [REG_W-1:0] en_reg;
  logic             rd_clr;
  logic             frm_lost;

  always_comb begin
    frm_lost = frm_unlocked | frm_crit | crc_excess;
    cond[0]  = frm_lost;
    cond[1]  = cmf_unlocked | crc_excess;
    cond[2]  = frm_lost | smf_crit;
    evt      = {evt_smf_err, evt_cmf_err, evt_fas_err};
  end

  fi_status #(.NSRC(NSRC)) u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .cond   (cond),
    .stat_q (stat_q),
    .toggle (toggle)
  );

  always_comb begin
    stat_reg = '0;
    set_w    = '0;
    for (int i = 0; i < NSRC; i++) begin
      stat_reg[LVL_LSB+i] = stat_q[i];
      set_w[LVL_LSB+i]    = toggle[i];
      set_w[EVT_LSB+i]    = evt[i];
    end
    rd_clr = rd_en && (addr_e'(rd_addr) == A_IND);
  end

  fi_latch #(.W(REG_W)) u_ind (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (set_w),
    .clr   (rd_clr),
    .q     (ind_reg)
  );

  fi_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W), .MASK(MASK)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_we    (en_we),
    .en_wdata (en_wdata),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .stat_reg (stat_reg),
    .ind_reg  (ind_reg),
    .en_reg   (en_reg),
    .rd_data  (rd_data)
  );

  always_comb irq = |(ind_reg & en_reg);
endmodule

// File: rtl/fi_checker.sv
module fi_checker #(
  parameter int NSRC  = 3,
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSRC-1:0]  evt,
  input logic             rd_en,
  input logic [1:0]       rd_addr,
  input logic [REG_W-1:0] rd_data,
  input logic             irq,
  input logic [REG_W-1:0] stat_reg,
  input logic [REG_W-1:0] ind_reg,
  input logic [REG_W-1:0] en_reg
);
  logic [REG_W-1:0] evt_w;
  always_comb evt_w = REG_W'(evt);

  a_r5_change_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_reg != $past(stat_reg)) |->
      ((ind_reg & (stat_reg ^ $past(stat_reg))) == (stat_reg ^ $past(stat_reg))));

  a_r6_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_w != '0) |=> ((ind_reg & $past(evt_w)) == $past(evt_w)));

  a_r7_clear_leaves_new_only: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 2'd1) |=>
      ((ind_reg & ~((stat_reg ^ $past(stat_reg)) | $past(evt_w))) == '0));

  a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 2'd1 && evt_w != '0) |=>
      ((ind_reg & $past(evt_w)) == $past(evt_w)));

  a_r9_no_irq_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (en_reg == '0) |-> !irq);

  a_r9_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((ind_reg & en_reg) != '0));

  a_r10_pad_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_data[3] == 1'b0 && rd_data[7] == 1'b0));
endmodule

bind framer_irq_ctrl fi_checker #(.NSRC(3), .REG_W(8)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .evt      ({evt_smf_err, evt_cmf_err, evt_fas_err}),
  .rd_en    (rd_en),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data),
  .irq      (irq),
  .stat_reg (stat_reg),
  .ind_reg  (ind_reg),
  .en_reg   (en_reg)
);

// File: tb/tb_framer_irq_ctrl.sv
module tb_framer_irq_ctrl;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm_unlocked = 0, frm_crit = 0, crc_excess = 0, cmf_unlocked = 0, smf_crit = 0;
  logic evt_fas_err = 0, evt_cmf_err = 0, evt_smf_err = 0;
  logic en_we = 0;
  logic [7:0] en_wdata = '0;
  logic rd_en = 0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic irq;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  framer_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .frm_unlocked(frm_unlocked), .frm_crit(frm_crit), .crc_excess(crc_excess),
    .cmf_unlocked(cmf_unlocked), .smf_crit(smf_crit),
    .evt_fas_err(evt_fas_err), .evt_cmf_err(evt_cmf_err), .evt_smf_err(evt_smf_err),
    .en_we(en_we), .en_wdata(en_wdata),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  // Monitor: pops the expected read value a quarter period after the driving edge.
  always @(negedge clk) begin
    #(CLK_P/4);
    if (rd_en) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rd_data !== e) begin
        errors++;
        $display("FAIL %s: rd_data actual=%h expected=%h", t, rd_data, e);
      end
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr_en(input logic [7:0] v);
    @(negedge clk);
    en_we = 1'b1; en_wdata = v;
    @(negedge clk);
    en_we = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    #(CLK_P/4);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq actual=%b expected=%b", t, irq, e);
    end
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: evt_fas_err = 1'b1;
      1: evt_cmf_err = 1'b1;
      default: evt_smf_err = 1'b1;
    endcase
    @(negedge clk);
    evt_fas_err = 0; evt_cmf_err = 0; evt_smf_err = 0;
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    // R1 reset state
    chk_irq(1'b0, "R1 irq");
    rd(2'd0, 8'h00, "R1 status");
    rd(2'd1, 8'h00, "R1 indication");
    rd(2'd2, 8'h00, "R1 enable");
    // R10 enable write masks pad bits
    wr_en(8'hFF);
    rd(2'd2, 8'h77, "R10 enable mask");
    rd(2'd3, 8'h00, "R7 unused address");
    // R6 event sets, R9 irq, R7 clear
    pulse(0);
    chk_irq(1'b1, "R9 irq on event");
    rd(2'd1, 8'h01, "R6 fas event");
    rd(2'd1, 8'h00, "R7 read clears");
    chk_irq(1'b0, "R9 irq after clear");
    // R2 R3 R4 R5 via crc_excess
    @(negedge clk); crc_excess = 1'b1;
    step();
    rd(2'd0, 8'h70, "R2 R3 R4 crc_excess status");
    rd(2'd1, 8'h70, "R5 rising sets");
    rd(2'd1, 8'h00, "R7 cleared");
    @(negedge clk); crc_excess = 1'b0;
    step();
    rd(2'd0, 8'h00, "R2 status low");
    rd(2'd1, 8'h70, "R5 falling sets");
    // R2 R4 frm_crit, R3 cmf_unlocked
    @(negedge clk); frm_crit = 1'b1;
    step();
    rd(2'd0, 8'h50, "R2 R4 frm_crit");
    @(negedge clk); cmf_unlocked = 1'b1; frm_crit = 1'b0;
    step();
    rd(2'd0, 8'h20, "R3 cmf_unlocked");
    @(negedge clk); cmf_unlocked = 1'b0; smf_crit = 1'b1; frm_unlocked = 1'b1;
    step();
    rd(2'd0, 8'h50, "R2 R4 frm_unlocked smf_crit");
    @(negedge clk); frm_unlocked = 1'b0;
    step();
    rd(2'd0, 8'h40, "R4 smf_crit only");
    rd(2'd1, 8'h70, "R5 accumulated changes");
    @(negedge clk); smf_crit = 1'b0;
    step();
    rd(2'd1, 8'h40, "R5 smf fall after clear");
    // R7 other addresses do not clear
    pulse(1);
    rd(2'd0, 8'h00, "R7 status read");
    rd(2'd2, 8'h77, "R7 enable read");
    rd(2'd3, 8'h00, "R7 addr3 read");
    rd(2'd1, 8'h02, "R7 indication kept");
    // R8 event during clearing read
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 2'd1; evt_smf_err = 1'b1;
    exp_q.push_back(8'h00); tag_q.push_back("R8 read during event");
    @(negedge clk);
    rd_en = 1'b0; evt_smf_err = 1'b0;
    rd(2'd1, 8'h04, "R8 event survives clear");
    // R8 status change during clearing read, R9 masking
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 2'd1; crc_excess = 1'b1; evt_cmf_err = 1'b1;
    exp_q.push_back(8'h00); tag_q.push_back("R8 read during change");
    @(negedge clk);
    rd_en = 1'b0; evt_cmf_err = 1'b0;
    wr_en(8'h01);
    chk_irq(1'b0, "R9 masked");
    wr_en(8'h20);
    chk_irq(1'b1, "R9 enabled bit5");
    rd(2'd1, 8'h72, "R8 change survives clear");
    chk_irq(1'b0, "R9 cleared");
    @(negedge clk); crc_excess = 1'b0;
    step();
    chk_irq(1'b1, "R9 fall re-raises");
    step();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule